// File: doc/BRIEF.md
# Lock Qualifier with Hold Gate and Automatic Loop Restart

This block sits between the raw lock detector of a clock-synthesis loop and the logic that consumes its lock status. The raw indication may chatter while the loop settles, so the block first brings it into the reference-clock domain through a short synchronizer. It then keeps the qualified lock output low until a programmable number of reference-clock cycles has passed since the loop was enabled or released from reset. Once that hold window has elapsed, the qualified output follows the synchronized raw lock.

The synchronized but ungated lock is also driven out for observers that want the unfiltered view. When the automatic restart option is on, a drop of the qualified lock raises a fixed-length loop-reset request. That request also re-arms the hold window, so lock has to be earned again before it is reported. Driving the synchronous reset low, or clearing the enable, returns the block to its idle state at once.

Top module: `lock_gate_top`

## Requirements
- R1: The raw lock input passes through a two-stage synchronizer. A change on it appears on `lock_raw` after the second rising reference-clock edge.
- R2: `hold_cycles` is 20 bits wide and takes values from 1 to 1,048,575. A large value keeps `lock_gated` low for at least that many cycles.
- R3: After enable, or after reset is released, `lock_gated` stays low until `hold_cycles` enabled rising edges have passed. From then on it equals `lock_raw`.
- R4: Toggling of the raw lock during the hold window does not restart the hold count.
- R5: With `rst_n` low or `loop_en` low at a rising edge, `lock_gated` and `lock_raw` are low after that edge and the hold count starts from zero. Neither condition produces a restart request.
- R6: With `auto_restart_en` high, a high-to-low transition of `lock_gated` while enabled raises `loop_reset_req` at the next rising edge. With `auto_restart_en` low, `loop_reset_req` never rises.
- R7: `loop_reset_req` stays high for exactly 4 cycles. While it is high, the hold count is held at zero. The full hold window is counted again after it falls, and the gate's own clearing does not retrigger a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| loop_en | input | 1 | Loop enable; low clears the block |
| hold_cycles | input | 20 | Hold window length in reference cycles |
| auto_restart_en | input | 1 | Enables restart request on lock loss |
| raw_lock_in | input | 1 | Asynchronous raw lock indication |
| lock_gated | output | 1 | Qualified lock |
| lock_raw | output | 1 | Synchronized, ungated lock |
| loop_reset_req | output | 1 | Loop-reset request pulse |

## Verification
The main function is driven with a steady raw lock, so the exact cycle the hold window opens can be told apart from one cycle early or late. A raw lock that chatters inside the window shows whether the count restarts. A lock drop after the window shows plain following with the restart option off, and the pulse timing plus the re-armed window with it on. A minimum window of 1 shows where the synchronizer latency dominates. A near-maximum window shows that the gate holds for long counts. Reset and disable applied while locked show that everything clears without a spurious request.

// File: rtl/lock_gate_pkg.sv
// Package: shared widths and constants for the lock qualifier.
// Assumes: one reference-clock domain; all sizes derive from these values.
package lock_gate_pkg;
    localparam int unsigned HOLD_W_DEF    = 20;
    localparam int unsigned SYNC_DEF      = 2;
    localparam int unsigned PULSE_LEN_DEF = 4;

    // Width needed to count a restart pulse of the given length.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction
endpackage

// File: rtl/lock_gate_sync.sv
// Module: multi-stage synchronizer for the raw lock indication.
// Assumes: input is asynchronous to clk; the chain is cleared while the
// block is inactive (reset or disabled).
module lock_gate_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic active,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            // Single stage: capture input directly.
            always_ff @(posedge clk) begin
                chain_q[0] <= active ? async_in : 1'b0;
            end
        end else begin : g_multi
            // Shift the input through the chain, clearing when inactive.
            always_ff @(posedge clk) begin
                if (!active) chain_q <= '0;
                else         chain_q <= {chain_q[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/lock_gate_hold.sv
// Module: hold-window counter.
// done_o rises once HOLD_W-bit count reaches hold_i and stays high
// until the block is deactivated or a restart clears it.
// Assumes: hold_i is stable while counting; a value of 0 acts as 1.
module lock_gate_hold #(
    parameter int unsigned HOLD_W = 20
) (
    input  logic              clk,
    input  logic              active,
    input  logic              restart,
    input  logic [HOLD_W-1:0] hold_i,
    output logic              done_o
);
    localparam int unsigned EXT_W = HOLD_W + 1;

    logic [HOLD_W-1:0] cnt_q;
    logic              done_q;
    logic [EXT_W-1:0]  cnt_next;

    assign cnt_next = {1'b0, cnt_q} + EXT_W'(1);

    // Count enabled cycles up to the programmed hold, then latch done.
    always_ff @(posedge clk) begin
        if (!active || restart) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            cnt_q <= cnt_next[HOLD_W-1:0];
            if (cnt_next >= {1'b0, hold_i}) done_q <= 1'b1;
        end
    end

    assign done_o = done_q;
endmodule

// File: rtl/lock_gate_restart.sv
// Module: automatic restart request generator.
// Watches the qualified lock for a falling edge while enabled and, if
// allowed, emits a fixed-length request. Only rst_n cuts a pulse short.
module lock_gate_restart #(
    parameter int unsigned PULSE_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic allow,
    input  logic gated_lock,
    output logic req_o,
    output logic clear_o
);
    import lock_gate_pkg::*;
    localparam int unsigned PW = cnt_width(PULSE_LEN);

    logic [PW-1:0] left_q;
    logic          prev_q;
    logic          busy;
    logic          trig;

    assign busy = (left_q != '0);
    assign trig = allow && active && prev_q && !gated_lock && !busy;

    // Remember the previous qualified lock for edge detection.
    always_ff @(posedge clk) begin
        prev_q <= active ? gated_lock : 1'b0;
    end

    // Load the pulse length on a trigger, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)      left_q <= '0;
        else if (trig)   left_q <= PW'(PULSE_LEN);
        else if (busy)   left_q <= left_q - PW'(1);
    end

    assign req_o   = busy;
    assign clear_o = trig || busy;
endmodule

// File: rtl/lock_gate_top.sv
// Module: lock qualifier top. Synchronizes raw lock, gates it with a
// programmable hold window and optionally requests a loop restart when
// qualified lock drops. Reset is synchronous, active low.
module lock_gate_top #(
    parameter int unsigned HOLD_W      = lock_gate_pkg::HOLD_W_DEF,
    parameter int unsigned SYNC_STAGES = lock_gate_pkg::SYNC_DEF,
    parameter int unsigned PULSE_LEN   = lock_gate_pkg::PULSE_LEN_DEF
) (
    input  logic              clk_ref,
    input  logic              rst_n,
    input  logic              loop_en,
    input  logic [HOLD_W-1:0] hold_cycles,
    input  logic              auto_restart_en,
    input  logic              raw_lock_in,
    output logic              lock_gated,
    output logic              lock_raw,
    output logic              loop_reset_req
);
    logic active;
    logic synced;
    logic hold_done;
    logic restart;

    assign active = rst_n && loop_en;

    lock_gate_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk_ref),
        .active   (active),
        .async_in (raw_lock_in),
        .sync_out (synced)
    );

    lock_gate_hold #(.HOLD_W(HOLD_W)) u_hold (
        .clk     (clk_ref),
        .active  (active),
        .restart (restart),
        .hold_i  (hold_cycles),
        .done_o  (hold_done)
    );

    lock_gate_restart #(.PULSE_LEN(PULSE_LEN)) u_restart (
        .clk        (clk_ref),
        .rst_n      (rst_n),
        .active     (active),
        .allow      (auto_restart_en),
        .gated_lock (lock_gated),
        .req_o      (loop_reset_req),
        .clear_o    (restart)
    );

    assign lock_raw   = synced;
    assign lock_gated = synced && hold_done;
endmodule

// File: rtl/lock_gate_checker.sv
// Checker: temporal properties of the lock qualifier, bound to the top.
module lock_gate_checker #(
    parameter int unsigned PULSE_LEN = 4
) (
    input logic clk_ref,
    input logic rst_n,
    input logic loop_en,
    input logic auto_restart_en,
    input logic lock_gated,
    input logic lock_raw,
    input logic loop_reset_req
);
    int unsigned run_q;

    // Length of the current run of high request samples.
    always_ff @(posedge clk_ref) begin
        if (!rst_n)              run_q <= 0;
        else if (loop_reset_req) run_q <= run_q + 1;
        else                     run_q <= 0;
    end

    p_disable_clears_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !loop_en |=> (!lock_gated && !lock_raw));

    p_gate_closed_after_enable_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(loop_en) |=> !lock_gated);

    p_req_needs_enable_r6: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(loop_reset_req) |-> $past(auto_restart_en));

    p_req_after_loss_r6: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(loop_reset_req) |-> $past(lock_gated, 2));

    p_pulse_length_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $fell(loop_reset_req) |-> (run_q == PULSE_LEN));

    p_gate_implies_raw_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
        lock_gated |-> lock_raw);
endmodule

bind lock_gate_top lock_gate_checker #(.PULSE_LEN(PULSE_LEN)) u_chk (
    .clk_ref         (clk_ref),
    .rst_n           (rst_n),
    .loop_en         (loop_en),
    .auto_restart_en (auto_restart_en),
    .lock_gated      (lock_gated),
    .lock_raw        (lock_raw),
    .loop_reset_req  (loop_reset_req)
);

// File: tb/lock_gate_top_tb_top.sv
// Scoreboard bench: driver pushes expected output triples tagged with a
// cycle number; a monitor pops and compares them at the falling edge.
module lock_gate_top_tb_top;
    logic        clk_ref = 1'b0;
    logic        rst_n = 1'b0;
    logic        loop_en = 1'b0;
    logic [19:0] hold_cycles = 20'd5;
    logic        auto_restart_en = 1'b0;
    logic        raw_lock_in = 1'b0;
    logic        lock_gated, lock_raw, loop_reset_req;

    typedef struct {
        int    cyc;
        logic  g;
        logic  r;
        logic  q;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;

    always #10 clk_ref = ~clk_ref;   // 50 MHz

    always @(posedge clk_ref) cyc <= cyc + 1;

    lock_gate_top dut_i (
        .clk_ref         (clk_ref),
        .rst_n           (rst_n),
        .loop_en         (loop_en),
        .hold_cycles     (hold_cycles),
        .auto_restart_en (auto_restart_en),
        .raw_lock_in     (raw_lock_in),
        .lock_gated      (lock_gated),
        .lock_raw        (lock_raw),
        .loop_reset_req  (loop_reset_req)
    );

    task automatic expect_at(int c, logic g, logic r, logic q, string tag);
        exp_t e;
        e.cyc = c; e.g = g; e.r = r; e.q = q; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk_ref);
    endtask

    // Monitor: compare every expectation due at this cycle.
    always @(negedge clk_ref) begin
        while (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
            exp_t e;
            e = exp_q.pop_front();
            n_chk++;
            if (e.cyc != cyc || lock_gated !== e.g || lock_raw !== e.r
                || loop_reset_req !== e.q) begin
                n_fail++;
                $display("FAIL %s cyc %0d: got g=%b r=%b q=%b expected g=%b r=%b q=%b (due %0d)",
                         e.tag, cyc, lock_gated, lock_raw, loop_reset_req,
                         e.g, e.r, e.q, e.cyc);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk_ref);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int c;
        // R5 reset state.
        step(2);
        expect_at(cyc + 1, 0, 0, 0, "R5 reset state");
        step(1);

        // R1/R3 release with steady raw lock, hold 5.
        c = cyc;
        rst_n = 1; loop_en = 1; raw_lock_in = 1; hold_cycles = 20'd5;
        expect_at(c + 1, 0, 0, 0, "R1 first stage only");
        expect_at(c + 2, 0, 1, 0, "R1 sync latency");
        expect_at(c + 4, 0, 1, 0, "R3 gate still closed");
        expect_at(c + 5, 1, 1, 0, "R3 gate opens");
        step(7);

        // R3/R6 lock drop with auto restart off: follow, no pulse.
        c = cyc;
        raw_lock_in = 0;
        expect_at(c + 1, 1, 1, 0, "R1 drop not yet visible");
        expect_at(c + 2, 0, 0, 0, "R3 follows drop");
        expect_at(c + 3, 0, 0, 0, "R6 no pulse when off");
        step(3);
        c = cyc;
        raw_lock_in = 1;
        expect_at(c + 2, 1, 1, 0, "R3 follows return without new hold");
        step(4);

        // R5 disable while locked.
        c = cyc;
        loop_en = 0;
        expect_at(c + 1, 0, 0, 0, "R5 disable clears");
        expect_at(c + 2, 0, 0, 0, "R5 no pulse on disable");
        step(3);

        // R4 chatter during hold 20 does not restart count.
        c = cyc;
        hold_cycles = 20'd20; loop_en = 1;
        expect_at(c + 19, 0, 1, 0, "R4 gate closed at 19");
        expect_at(c + 20, 1, 1, 0, "R4 gate opens at 20 despite chatter");
        step(5);
        raw_lock_in = 0;
        step(3);
        raw_lock_in = 1;
        step(15);

        // R6/R7 auto restart on lock loss, hold 5.
        hold_cycles = 20'd5; auto_restart_en = 1;
        step(1);
        c = cyc;
        raw_lock_in = 0;
        expect_at(c + 2, 0, 0, 0, "R6 gated falls");
        expect_at(c + 3, 0, 0, 1, "R6 request rises");
        step(2);
        raw_lock_in = 1;
        expect_at(c + 4, 0, 1, 1, "R7 request held, gate closed");
        expect_at(c + 6, 0, 1, 1, "R7 request fourth cycle");
        expect_at(c + 7, 0, 1, 0, "R7 request ends after 4");
        expect_at(c + 11, 0, 1, 0, "R7 hold re-armed");
        expect_at(c + 12, 1, 1, 0, "R7 relock after full hold");
        expect_at(c + 13, 1, 1, 0, "R7 no retrigger");
        step(14);

        // R5 reset while locked with auto restart on: no pulse.
        c = cyc;
        rst_n = 0;
        expect_at(c + 1, 0, 0, 0, "R5 reset clears");
        expect_at(c + 3, 0, 0, 0, "R5 no pulse on reset");
        step(3);

        // R2 minimum hold of 1: synchronizer dominates.
        c = cyc;
        rst_n = 1; hold_cycles = 20'd1;
        expect_at(c + 1, 0, 0, 0, "R2 hold 1 first edge");
        expect_at(c + 2, 1, 1, 0, "R2 hold 1 opens");
        step(4);

        // R2 near-maximum hold keeps gate closed.
        loop_en = 0;
        step(2);
        c = cyc;
        hold_cycles = 20'hFFFFF; loop_en = 1;
        expect_at(c + 10, 0, 1, 0, "R2 large hold closed");
        expect_at(c + 60, 0, 1, 0, "R2 large hold still closed");
        step(62);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule